// File: doc/BRIEF.md
# Two-Phase Event Control Chain

This block is a clocked, synthesizable model of a self-timed control fabric. Every control line carries events as transitions: one toggle of a line is one event, and there is no return-to-zero phase. Each state of the control chain holds the token for exactly as long as its operations take, because it passes control on only when the done events of its datapath units come back. Data travels single-rail beside the events and is bundled with them: the data is registered in the same clock edge that issues the matching request event.

The chain is built from four primitive cells. An XOR merge forms the OR of events into the entry state (an external start event or a loop-back event). A Muller C-element joins the done events of a group of parallel units. An acknowledge demultiplexer fronts one shared unit used by two states, so that each done event reaches only the state that asked. A condition-steered selector sends the final event either back to the entry state or out as a finish event. The entry state requests all parallel units at once. The second state is chained: it requests the shared unit, forwards that unit's acknowledge as the request to a follow-on unit, and takes the follow-on unit's done event as its completion. The third state requests the shared unit again and passes its acknowledge to the selector.

Top module: `evt_ctrl_chain`

## Requirements
- R1: After reset every event output (`par_req`, `shr_req`, `chain_req`, `fin_ev`) is 0 and `shr_data` is 0; the join cell starts at 0 with all its inputs at 0.
- R2: A toggle of `go_ev`, or a loop-back event from the selector, toggles every bit of `par_req` together, combinationally in the same cycle.
- R3: The shared unit is first requested (`shr_req` toggles) exactly two clock edges after the last of the `par_done` bits has toggled, whatever their order, spacing or coincidence, and never before that last toggle.
- R4: A request from the join (slot 0) toggles `shr_req` at the next clock edge and loads `shr_data` with `src0_data`; a request from the chained state (slot 1) does the same with `src1_data`; a new shared request is issued only when no earlier one is outstanding.
- R5: While a shared request is outstanding (`shr_req` differs from `shr_done`), `shr_data` holds the value loaded at the request, and changes on `src0_data` or `src1_data` have no effect on it.
- R6: A toggle of `shr_done` produces one acknowledge event, one clock edge later, on the slot that made the request only: slot 0 toggles `chain_req`; slot 1 leaves `chain_req` unchanged and feeds the selector.
- R7: A toggle of `chain_done` is the chained state's completion and issues the slot 1 shared request: `shr_req` toggles at the next clock edge with `src1_data`.
- R8: One clock edge after the slot 1 acknowledge, the selector toggles exactly one output: with `cond` = 1 it toggles the loop-back, which re-requests all parallel units (`par_req` toggles), and with `cond` = 0 it toggles `fin_ev`.
- R9: `cond` is sampled only at the clock edge where the selector sees its input event; changing `cond` at any other time has no effect on `fin_ev` or `par_req`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| go_ev | input | 1 | Start event (toggle) into the entry state |
| cond | input | 1 | Level condition steering the selector |
| par_req | output | NPAR | Request events to the parallel units |
| par_done | input | NPAR | Done events from the parallel units |
| shr_req | output | 1 | Request event to the shared unit |
| shr_data | output | DW | Operand bundled with `shr_req` |
| shr_done | input | 1 | Done event from the shared unit |
| src0_data | input | DW | Operand for the join-state request |
| src1_data | input | DW | Operand for the chained-state request |
| chain_req | output | 1 | Request event to the follow-on unit |
| chain_done | input | 1 | Done event from the follow-on unit |
| fin_ev | output | 1 | Finish event when the condition is false |

## Verification
The bench sweeps every completion order of three parallel units with pseudo-random gaps, including several units completing in the same cycle; a join that fired on the first or an odd number of done toggles would request the shared unit early, and one that missed coincident toggles would never fire. It changes the source operands while the shared unit is busy, where a demultiplexer that registered data late or followed its sources would break the bundling. It swaps which state owns the shared unit on every pass, so a demultiplexer that routed the acknowledge by the current request line instead of the captured one would toggle the wrong state. It also flips `cond` before and after the selector's event, which a selector that latched its condition continuously would get wrong.

// File: rtl/evt_pkg.sv
// Package: shared constants and helpers for the two-phase event chain.
// Assumes: slot numbering of the shared unit is fixed by the chain topology.
package evt_pkg;
    // Slot that the join (entry state completion) uses on the shared unit.
    localparam int SLOT_JOIN  = 0;
    // Slot that the chained state uses on the shared unit.
    localparam int SLOT_CHAIN = 1;
    // Number of requesters on the shared unit.
    localparam int NUM_SLOTS  = 2;

    // Width of a slot index for a given slot count (never zero).
    function automatic int slot_w(input int n);
        return (n > 1) ? $clog2(n) : 1;
    endfunction
endpackage

// File: rtl/evt_merge.sv
// Module: evt_merge
// XOR merge of N two-phase event lines. Each toggle on any input gives one
// toggle on the output.
// Assumes: no two inputs toggle in the same cycle (they would cancel).
module evt_merge #(
    parameter int N = 2
) (
    input  logic [N-1:0] ev_in,
    output logic         ev_out
);
    // Parity of the inputs is the merged event line.
    always_comb begin
        ev_out = ^ev_in;
    end
endmodule

// File: rtl/evt_celem.sv
// Module: evt_celem
// Registered Muller C-element over N event lines. Output follows the inputs
// when they all agree, else holds; so it toggles once every input has toggled
// the same number of times. One clock edge of latency.
// Assumes: inputs are zero at reset; each input toggles at most once per round.
module evt_celem #(
    parameter int N = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] ev_in,
    output logic         ev_out
);
    logic out_q;
    logic all_hi;
    logic all_lo;

    // Detect agreement of all inputs.
    always_comb begin
        all_hi = &ev_in;
        all_lo = ~(|ev_in);
    end

    // Hold the output until the inputs agree, then follow them.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_q <= 1'b0;
        end else if (all_hi) begin
            out_q <= 1'b1;
        end else if (all_lo) begin
            out_q <= 1'b0;
        end
    end

    assign ev_out = out_q;
endmodule

// File: rtl/evt_select.sv
// Module: evt_select
// Condition-steered event selector. On an input event, the level of cond at
// that clock edge decides whether the true or the false output toggles.
// Assumes: input events are at least one cycle apart.
module evt_select (
    input  logic clk,
    input  logic rst_n,
    input  logic ev_in,
    input  logic cond,
    output logic ev_true,
    output logic ev_false
);
    logic seen_q;
    logic true_q;
    logic false_q;
    logic fire;

    // An event is pending when the input differs from the last one consumed.
    always_comb begin
        fire = ev_in ^ seen_q;
    end

    // Consume the event and steer it by the sampled condition.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            seen_q  <= 1'b0;
            true_q  <= 1'b0;
            false_q <= 1'b0;
        end else if (fire) begin
            seen_q <= ev_in;
            if (cond) begin
                true_q <= ~true_q;
            end else begin
                false_q <= ~false_q;
            end
        end
    end

    assign ev_true  = true_q;
    assign ev_false = false_q;
endmodule

// File: rtl/evt_ackdemux.sv
// Module: evt_ackdemux
// Port of a shared datapath unit. Merges the request events of NS slots into
// one registered request, registers the bundled operand of the requesting
// slot in the same edge, captures the slot index, and routes the unit's done
// event back to that slot only.
// Assumes: at most one request outstanding; slots never request together.
module evt_ackdemux #(
    parameter int NS = 2,
    parameter int DW = 8
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [NS-1:0]        slot_req,
    input  logic [NS-1:0][DW-1:0] slot_data,
    output logic [NS-1:0]        slot_ack,
    output logic                 unit_req,
    output logic [DW-1:0]        unit_data,
    input  logic                 unit_done
);
    localparam int SW = evt_pkg::slot_w(NS);

    logic [NS-1:0] req_seen_q;
    logic [NS-1:0] req_new;
    logic [NS-1:0] ack_q;
    logic [SW-1:0] sel_q;
    logic [SW-1:0] new_idx;
    logic          req_q;
    logic          done_seen_q;
    logic [DW-1:0] data_q;
    logic          any_new;
    logic          done_ev;

    // Find which slot raised a new request event.
    always_comb begin
        req_new = slot_req ^ req_seen_q;
        any_new = |req_new;
        done_ev = unit_done ^ done_seen_q;
        new_idx = '0;
        for (int i = NS - 1; i >= 0; i--) begin
            if (req_new[i]) begin
                new_idx = SW'(i);
            end
        end
    end

    // Issue the request with its data and capture the requesting slot.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            req_seen_q <= '0;
            sel_q      <= '0;
            req_q      <= 1'b0;
            data_q     <= '0;
        end else if (any_new) begin
            req_seen_q <= slot_req;
            sel_q      <= new_idx;
            req_q      <= ~req_q;
            data_q     <= slot_data[new_idx];
        end
    end

    // Route the done event to the slot captured at request time.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            done_seen_q <= 1'b0;
            ack_q       <= '0;
        end else if (done_ev) begin
            done_seen_q  <= unit_done;
            ack_q[sel_q] <= ~ack_q[sel_q];
        end
    end

    assign slot_ack  = ack_q;
    assign unit_req  = req_q;
    assign unit_data = data_q;
endmodule

// File: rtl/evt_ctrl_chain.sv
// Module: evt_ctrl_chain
// Three-state two-phase control chain. Entry state (merge of start and
// loop-back) requests NPAR parallel units and joins their done events.
// The join requests the shared unit (slot 0); its acknowledge is chained as
// the request of a follow-on unit, whose done requests the shared unit again
// (slot 1). That acknowledge goes to a selector: loop back or finish.
// Assumes: the environment toggles go_ev only while the chain is idle and
// answers each request with exactly one done event.
module evt_ctrl_chain
    import evt_pkg::*;
#(
    parameter int NPAR = 3,
    parameter int DW   = 8
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            go_ev,
    input  logic            cond,
    output logic [NPAR-1:0] par_req,
    input  logic [NPAR-1:0] par_done,
    output logic            shr_req,
    output logic [DW-1:0]   shr_data,
    input  logic            shr_done,
    input  logic [DW-1:0]   src0_data,
    input  logic [DW-1:0]   src1_data,
    output logic            chain_req,
    input  logic            chain_done,
    output logic            fin_ev
);
    logic                          loop_ev;
    logic                          entry_ev;
    logic                          join_ev;
    logic [NUM_SLOTS-1:0]          slot_req;
    logic [NUM_SLOTS-1:0][DW-1:0]  slot_data;
    logic [NUM_SLOTS-1:0]          slot_ack;

    // Entry state: OR of the start event and the loop-back event.
    evt_merge #(.N(2)) u_entry (
        .ev_in  ({loop_ev, go_ev}),
        .ev_out (entry_ev)
    );

    // Entry state fans its event out as the request to every parallel unit.
    always_comb begin
        par_req = {NPAR{entry_ev}};
    end

    // Entry state completion: AND of all parallel done events.
    evt_celem #(.N(NPAR)) u_join (
        .clk    (clk),
        .rst_n  (rst_n),
        .ev_in  (par_done),
        .ev_out (join_ev)
    );

    // Slot requests and their bundled operands on the shared unit.
    always_comb begin
        slot_req             = '0;
        slot_data            = '0;
        slot_req[SLOT_JOIN]  = join_ev;
        slot_req[SLOT_CHAIN] = chain_done;
        slot_data[SLOT_JOIN]  = src0_data;
        slot_data[SLOT_CHAIN] = src1_data;
    end

    // Shared unit port with acknowledge demultiplexer.
    evt_ackdemux #(.NS(NUM_SLOTS), .DW(DW)) u_share (
        .clk       (clk),
        .rst_n     (rst_n),
        .slot_req  (slot_req),
        .slot_data (slot_data),
        .slot_ack  (slot_ack),
        .unit_req  (shr_req),
        .unit_data (shr_data),
        .unit_done (shr_done)
    );

    // Chained state: slot 0 acknowledge becomes the follow-on request.
    always_comb begin
        chain_req = slot_ack[SLOT_JOIN];
    end

    // Final state: steer slot 1 acknowledge by the condition.
    evt_select u_branch (
        .clk      (clk),
        .rst_n    (rst_n),
        .ev_in    (slot_ack[SLOT_CHAIN]),
        .cond     (cond),
        .ev_true  (loop_ev),
        .ev_false (fin_ev)
    );
endmodule

// File: rtl/evt_ctrl_chain_chk.sv
// Module: evt_ctrl_chain_chk
// Port-level protocol checker for evt_ctrl_chain, bound to every instance.
// Assumes: the environment keeps one shared request outstanding at most.
module evt_ctrl_chain_chk #(
    parameter int NPAR = 3,
    parameter int DW   = 8
) (
    input logic            clk,
    input logic            rst_n,
    input logic [NPAR-1:0] par_req,
    input logic [NPAR-1:0] par_done,
    input logic            shr_req,
    input logic [DW-1:0]   shr_data,
    input logic            shr_done,
    input logic            chain_req,
    input logic            fin_ev
);
    AST_RESET_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (par_req == '0 && !shr_req && !chain_req && !fin_ev && shr_data == '0)); // R1

    AST_JOIN_AFTER_ALL: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(shr_req) |-> (par_done == '0 || par_done == '1)); // R3

    AST_NO_OVERLAP: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(shr_req) |-> ($past(shr_req) == $past(shr_done))); // R4

    AST_DATA_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        ((shr_req != shr_done) && $stable(shr_req)) |-> $stable(shr_data)); // R5

    AST_ACK_FROM_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(chain_req) |-> ($past(shr_done) != $past(shr_done, 2))); // R6

    AST_ONE_BRANCH: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(fin_ev) |-> $stable(par_req)); // R8
endmodule

bind evt_ctrl_chain evt_ctrl_chain_chk #(.NPAR(NPAR), .DW(DW)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .par_req   (par_req),
    .par_done  (par_done),
    .shr_req   (shr_req),
    .shr_data  (shr_data),
    .shr_done  (shr_done),
    .chain_req (chain_req),
    .fin_ev    (fin_ev)
);

// File: tb/evt_ctrl_chain_tb.sv
// Bench: sweeps all completion orders of three parallel units with
// pseudo-random gaps and both selector outcomes; checks event timing at ports.
module evt_ctrl_chain_tb;
    localparam int CLK_PERIOD = 10;
    localparam int NPAR       = 3;
    localparam int DW         = 8;
    localparam int WATCHDOG   = 150000;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            go_ev = 1'b0;
    logic            cond = 1'b0;
    logic [NPAR-1:0] par_req;
    logic [NPAR-1:0] par_done = '0;
    logic            shr_req;
    logic [DW-1:0]   shr_data;
    logic            shr_done = 1'b0;
    logic [DW-1:0]   src0_data = '0;
    logic [DW-1:0]   src1_data = '0;
    logic            chain_req;
    logic            chain_done = 1'b0;
    logic            fin_ev;

    int          n_chk = 0;
    int          n_fail = 0;
    bit          ended = 1'b0;
    int unsigned seed = 32'd12345;

    bit          e_par = 1'b0;
    bit          e_shr = 1'b0;
    bit          e_chain = 1'b0;
    bit          e_fin = 1'b0;
    logic [DW-1:0] e_data = '0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    evt_ctrl_chain #(.NPAR(NPAR), .DW(DW)) u_dut (
        .clk        (clk),
        .rst_n      (rst_n),
        .go_ev      (go_ev),
        .cond       (cond),
        .par_req    (par_req),
        .par_done   (par_done),
        .shr_req    (shr_req),
        .shr_data   (shr_data),
        .shr_done   (shr_done),
        .src0_data  (src0_data),
        .src1_data  (src1_data),
        .chain_req  (chain_req),
        .chain_done (chain_done),
        .fin_ev     (fin_ev)
    );

    // Record one check and report a failure.
    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // Pseudo-random gap of 0..3 cycles.
    function automatic int gap();
        seed = seed * 32'd1103515245 + 32'd12345;
        return int'(seed[17:16]);
    endfunction

    // Print the summary and stop.
    task automatic finish_up();
        ended = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    endtask

    // One pass through the chain; positioned at a negedge on entry and exit.
    task automatic run_pass(input int p, input int k, input bit cv);
        int ord[NPAR];
        logic [DW-1:0] v0;
        logic [DW-1:0] v1;
        ord[0] = p / 2;
        ord[1] = (ord[0] == 0) ? 1 : 0;
        ord[2] = (ord[0] == 2) ? 1 : 2;
        if (p % 2 == 1) begin
            int t;
            t = ord[1];
            ord[1] = ord[2];
            ord[2] = t;
        end
        v0 = DW'(p * 37 + k * 11 + 5);
        v1 = DW'(~(p * 19 + k * 7));
        cond = ~cv;
        src0_data = v0;
        // Parallel units complete in order ord with random gaps.
        for (int i = 0; i < NPAR; i++) begin
            int g;
            g = (i == 0) ? gap() + 1 : gap();
            for (int c = 0; c < g; c++) begin
                @(negedge clk);
                chk(shr_req == e_shr, "R3 shared request before last done", int'(shr_req), int'(e_shr));
            end
            par_done[ord[i]] = ~par_done[ord[i]];
        end
        @(negedge clk);
        chk(shr_req == e_shr, "R3 shared request one edge after last done", int'(shr_req), int'(e_shr));
        @(negedge clk);
        e_shr = ~e_shr;
        e_data = v0;
        chk(shr_req == e_shr, "R3 shared request two edges after last done", int'(shr_req), int'(e_shr));
        chk(shr_data == e_data, "R4 slot 0 operand", int'(shr_data), int'(e_data));
        src0_data = ~v0;
        src1_data = ~v1;
        for (int c = 0; c < gap(); c++) begin
            @(negedge clk);
            chk(shr_data == e_data, "R5 operand held during slot 0 request", int'(shr_data), int'(e_data));
        end
        shr_done = ~shr_done;
        @(negedge clk);
        e_chain = ~e_chain;
        chk(chain_req == e_chain, "R6 slot 0 acknowledge to chained unit", int'(chain_req), int'(e_chain));
        chk(shr_req == e_shr, "R6 no new shared request on acknowledge", int'(shr_req), int'(e_shr));
        for (int c = 0; c < gap(); c++) begin
            @(negedge clk);
            chk(shr_req == e_shr, "R7 no shared request before chained done", int'(shr_req), int'(e_shr));
        end
        src1_data = v1;
        chain_done = ~chain_done;
        @(negedge clk);
        e_shr = ~e_shr;
        e_data = v1;
        chk(shr_req == e_shr, "R7 chained done issues slot 1 request", int'(shr_req), int'(e_shr));
        chk(shr_data == e_data, "R4 slot 1 operand", int'(shr_data), int'(e_data));
        src0_data = v1 ^ 8'h5a;
        src1_data = v0;
        for (int c = 0; c < gap(); c++) begin
            @(negedge clk);
            chk(shr_data == e_data, "R5 operand held during slot 1 request", int'(shr_data), int'(e_data));
        end
        cond = cv;
        shr_done = ~shr_done;
        @(negedge clk);
        chk(chain_req == e_chain, "R6 slot 1 acknowledge not on chained unit", int'(chain_req), int'(e_chain));
        chk(fin_ev == e_fin, "R8 finish not before selector edge", int'(fin_ev), int'(e_fin));
        chk(par_req == {NPAR{e_par}}, "R8 loop not before selector edge", int'(par_req), int'({NPAR{e_par}}));
        @(negedge clk);
        if (cv) begin
            e_par = ~e_par;
        end else begin
            e_fin = ~e_fin;
        end
        chk(par_req == {NPAR{e_par}}, "R8 R2 loop-back re-requests parallel units", int'(par_req), int'({NPAR{e_par}}));
        chk(fin_ev == e_fin, "R8 finish event", int'(fin_ev), int'(e_fin));
        cond = ~cv;
        @(negedge clk);
        chk(par_req == {NPAR{e_par}}, "R9 late cond change no loop", int'(par_req), int'({NPAR{e_par}}));
        chk(fin_ev == e_fin, "R9 late cond change no finish", int'(fin_ev), int'(e_fin));
    endtask

    // Watchdog: a hung run counts as a failure.
    initial begin
        repeat (WATCHDOG) @(posedge clk);
        if (!ended) begin
            n_fail++;
            $display("FAIL watchdog actual=%0d expected=%0d", WATCHDOG, 0);
            finish_up();
        end
    end

    // Main stimulus.
    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(par_req == '0, "R1 par_req after reset", int'(par_req), 0);
        chk(shr_req == 1'b0, "R1 shr_req after reset", int'(shr_req), 0);
        chk(shr_data == '0, "R1 shr_data after reset", int'(shr_data), 0);
        chk(chain_req == 1'b0, "R1 chain_req after reset", int'(chain_req), 0);
        chk(fin_ev == 1'b0, "R1 fin_ev after reset", int'(fin_ev), 0);
        @(negedge clk);
        chk(shr_req == 1'b0, "R1 join quiet with inputs at zero", int'(shr_req), 0);
        for (int p = 0; p < 6; p++) begin
            for (int k = 0; k < 3; k++) begin
                bit cv;
                cv = (k != 2);
                if (k == 0) begin
                    go_ev = ~go_ev;
                    e_par = ~e_par;
                    #1;
                    chk(par_req == {NPAR{e_par}}, "R2 start event requests all units", int'(par_req), int'({NPAR{e_par}}));
                end
                run_pass(p, k, cv);
            end
        end
        repeat (3) @(negedge clk);
        chk(fin_ev == e_fin, "R8 idle after final finish", int'(fin_ev), int'(e_fin));
        finish_up();
    end
endmodule